// File: doc/BRIEF.md
# Vector Length Control Registers

This unit holds the two length registers a scalar core needs to run vector-style loops: a maximum length (an upper bound that software chooses) and a current length (the element count that the next vector operations use). Both are reached through a CSR access port. The unit decodes four CSR addresses and clamps every value it stores. On a read-write access it returns a read-back value.

Writing the maximum-length CSR stores the written value, limited to 63. Writing the set-length CSR is an indirect operation. The written data names a general-purpose register. The unit reads that register through a register-file read port and clamps its contents against the maximum length. It stores the result as the current length and writes the same result back into the named register through a register-file write port. Software therefore finds the granted length in its own register after one CSR swap. The CSR swap also returns the granted length.

Top module: `vlen_ctrl`

## Requirements
- R1: Address decode: 0xCF0 reads the current length, 0xCF1 sets it, 0xCF2 reads the maximum length and 0xCF3 sets the maximum. A read without write at 0xCF1 or 0xCF3 returns the current or the maximum length respectively.
- R2: A write to 0xCF3 stores min(write data, 63) as the maximum length and returns the maximum held before the write.
- R3: On a write to 0xCF1, bits [4:0] of the write data give a register index and the other bits are ignored. The new current length is min(maximum length, contents of that register).
- R4: The new current length is written back into the indexed register. A write-back to register 0 is suppressed, so no register-file write occurs.
- R5: A write to 0xCF1 returns the current length after the update.
- R6: A write to 0xCF0 or 0xCF2 changes no state and returns the register's value.
- R7: After reset both length registers read as zero.
- R8: Accesses to 0xCF0, 0xCF2 and 0xCF3, and illegal accesses, raise done in the cycle after the request. A write to 0xCF1 drives the register-file read address in the first cycle and the write port in the second, and raises done in the third.
- R9: An access to any other address raises the illegal flag together with done and returns zero. It changes neither length register and makes no register-file write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| csr_req_i | input | 1 | access request, one cycle, only while the unit is idle |
| csr_we_i | input | 1 | access writes data |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | write data |
| csr_rdata_o | output | XLEN | read-back value, valid with done |
| csr_done_o | output | 1 | one-cycle completion strobe |
| csr_illegal_o | output | 1 | address not decoded, valid with done |
| rf_raddr_o | output | 5 | register-file read index |
| rf_rdata_i | input | XLEN | register-file read data, same cycle |
| rf_we_o | output | 1 | register-file write enable |
| rf_waddr_o | output | 5 | register-file write index |
| rf_wdata_o | output | XLEN | register-file write data |

## Verification
A wrong maximum length shows up at the ports as soon as it is read at 0xCF2. It also shows up on the next length set, where the granted value and the value written back come out wrong. A wrong current length shows up one cycle later, at the next 0xCF0 read. A faulty sequencer shows up as a done strobe at the wrong cycle or as a write-back with the wrong index or data. A write to register 0 is visible on the write port in the cycle it happens.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_GET_VL  = 12'hCF0;
  localparam logic [ADDR_W-1:0] A_SET_VL  = 12'hCF1;
  localparam logic [ADDR_W-1:0] A_GET_MVL = 12'hCF2;
  localparam logic [ADDR_W-1:0] A_SET_MVL = 12'hCF3;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_GET_VL,
    OP_GET_MVL,
    OP_SET_VL,
    OP_SET_MVL,
    OP_BAD
  } vlen_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WB
  } vlen_st_e;
endpackage

// File: rtl/vlen_decode.sv
module vlen_decode
  import vlen_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output vlen_op_e          op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (req_i) begin
      unique case (addr_i)
        A_GET_VL:  op_o = OP_GET_VL;
        A_GET_MVL: op_o = OP_GET_MVL;
        A_SET_VL:  op_o = we_i ? OP_SET_VL  : OP_GET_VL;
        A_SET_MVL: op_o = we_i ? OP_SET_MVL : OP_GET_MVL;
        default:   op_o = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/vlen_clamp.sv
module vlen_clamp #(
  parameter int unsigned NW = 6,
  parameter int unsigned WW = 64
) (
  input  logic [NW-1:0] lim_i,
  input  logic [WW-1:0] val_i,
  output logic [NW-1:0] min_o
);
  // wide compare so that upper bits of val_i count
  always_comb begin
    if (val_i < WW'(lim_i)) min_o = val_i[NW-1:0];
    else                    min_o = lim_i;
  end
endmodule

// File: rtl/vlen_seq.sv
module vlen_seq
  import vlen_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = 6,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vlen_op_e         op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LEN_W-1:0] mvl_new_i,
  input  logic [LEN_W-1:0] vl_new_i,
  output logic [LEN_W-1:0] mvl_o,
  output logic [XLEN-1:0]  rdata_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic [IDX_W-1:0] rf_idx_o,
  output logic             rf_we_o,
  output logic [XLEN-1:0]  rf_wdata_o
);
  vlen_st_e         st_q;
  logic [LEN_W-1:0] vl_q, mvl_q;
  logic [IDX_W-1:0] idx_q;
  logic [XLEN-1:0]  rdata_q;
  logic             done_q, bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vl_q    <= '0;
      mvl_q   <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          unique case (op_i)
            OP_GET_VL: begin
              rdata_q <= XLEN'(vl_q);
              done_q  <= 1'b1;
            end
            OP_GET_MVL: begin
              rdata_q <= XLEN'(mvl_q);
              done_q  <= 1'b1;
            end
            OP_SET_MVL: begin
              rdata_q <= XLEN'(mvl_q);
              mvl_q   <= mvl_new_i;
              done_q  <= 1'b1;
            end
            OP_SET_VL: begin
              idx_q <= idx_i;
              st_q  <= ST_RD;
            end
            OP_BAD: begin
              rdata_q <= '0;
              done_q  <= 1'b1;
              bad_q   <= 1'b1;
            end
            default: ;
          endcase
        end
        ST_RD: begin
          vl_q <= vl_new_i;
          st_q <= ST_WB;
        end
        ST_WB: begin
          rdata_q <= XLEN'(vl_q);
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mvl_o      = mvl_q;
  assign rdata_o    = rdata_q;
  assign done_o     = done_q;
  assign illegal_o  = bad_q;
  assign rf_idx_o   = idx_q;
  assign rf_we_o    = (st_q == ST_WB) && (idx_q != '0);
  assign rf_wdata_o = XLEN'(vl_q);

  // R4
  wb_not_x0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_idx_o != '0);

  // R3
  vl_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WB) |-> vl_q <= mvl_q);

  // R5
  setvl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WB) |=> done_o && rdata_o == XLEN'(vl_q));

  // R9
  bad_no_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && op_i == OP_BAD) |=> illegal_o && $stable(vl_q) && $stable(mvl_q));

  // R8
  plain_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && (op_i == OP_GET_VL || op_i == OP_GET_MVL || op_i == OP_SET_MVL))
      |=> done_o && !illegal_o);
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = 6,
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_req_i,
  input  logic              csr_we_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_done_o,
  output logic              csr_illegal_o,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [XLEN-1:0]   rf_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'((1 << LEN_W) - 1);

  vlen_op_e         op;
  logic [LEN_W-1:0] mvl, mvl_new, vl_new;
  logic [IDX_W-1:0] rf_idx;

  vlen_decode u_dec (
    .req_i  (csr_req_i),
    .we_i   (csr_we_i),
    .addr_i (csr_addr_i),
    .op_o   (op)
  );

  vlen_clamp #(.NW(LEN_W), .WW(XLEN)) u_mvl_clamp (
    .lim_i (LEN_CAP),
    .val_i (csr_wdata_i),
    .min_o (mvl_new)
  );

  vlen_clamp #(.NW(LEN_W), .WW(XLEN)) u_vl_clamp (
    .lim_i (mvl),
    .val_i (rf_rdata_i),
    .min_o (vl_new)
  );

  vlen_seq #(.XLEN(XLEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .idx_i      (csr_wdata_i[IDX_W-1:0]),
    .mvl_new_i  (mvl_new),
    .vl_new_i   (vl_new),
    .mvl_o      (mvl),
    .rdata_o    (csr_rdata_o),
    .done_o     (csr_done_o),
    .illegal_o  (csr_illegal_o),
    .rf_idx_o   (rf_idx),
    .rf_we_o    (rf_we_o),
    .rf_wdata_o (rf_wdata_o)
  );

  assign rf_raddr_o = rf_idx;
  assign rf_waddr_o = rf_idx;
endmodule

// File: tb/sim_vlen_ctrl.sv
module sim_vlen_ctrl;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [11:0]     addr = '0;
  logic [XLEN-1:0] wdata = '0;
  logic [XLEN-1:0] rdata, rf_rdata, rf_wdata;
  logic            done, illegal, rf_we;
  logic [4:0]      rf_raddr, rf_waddr;

  logic [XLEN-1:0] rf [32];
  int              wr_cnt = 0;
  int              n_chk = 0, n_bad = 0;
  int              cyc = 0;

  always #10 clk = ~clk;   // 50 MHz

  vlen_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .csr_done_o(done), .csr_illegal_o(illegal), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata)
  );

  assign rf_rdata = (rf_raddr == 5'd0) ? '0 : rf[rf_raddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rf_we) begin
      rf[rf_waddr] <= rf_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string rq, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic csr_op(input logic [11:0] a, input logic w, input logic [XLEN-1:0] d,
                        output logic [XLEN-1:0] rd, output logic ill, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata; ill = illegal;
  endtask

  task automatic t_reset();
    logic [XLEN-1:0] rd; logic ill; int lat;
    csr_op(12'hCF0, 1'b0, '0, rd, ill, lat);
    check("R7 vl after reset", rd, 0);
    check("R8 get latency", lat, 1);
    csr_op(12'hCF2, 1'b0, '0, rd, ill, lat);
    check("R7 mvl after reset", rd, 0);
    csr_op(12'hCF1, 1'b0, '0, rd, ill, lat);
    check("R1 CF1 read returns vl", rd, 0);
  endtask

  task automatic t_setvl_zero_max();
    logic [XLEN-1:0] rd; logic ill; int lat;
    rf[3] = 64'd17;
    csr_op(12'hCF1, 1'b1, 64'd3, rd, ill, lat);
    check("R3 vl with mvl 0", rd, 0);
    check("R4 reg3 written 0", rf[3], 0);
  endtask

  task automatic t_set_mvl();
    logic [XLEN-1:0] rd; logic ill; int lat;
    csr_op(12'hCF3, 1'b1, 64'd10, rd, ill, lat);
    check("R2 set mvl returns old", rd, 0);
    check("R8 set mvl latency", lat, 1);
    csr_op(12'hCF3, 1'b0, '0, rd, ill, lat);
    check("R1 CF3 read returns mvl", rd, 10);
    csr_op(12'hCF3, 1'b1, 64'd100, rd, ill, lat);
    check("R2 set mvl returns old 10", rd, 10);
    csr_op(12'hCF2, 1'b0, '0, rd, ill, lat);
    check("R2 mvl clamped to 63", rd, 63);
    csr_op(12'hCF3, 1'b1, 64'h1_0000_0005, rd, ill, lat);
    csr_op(12'hCF2, 1'b0, '0, rd, ill, lat);
    check("R2 wide value clamped", rd, 63);
  endtask

  task automatic t_set_vl();
    logic [XLEN-1:0] rd; logic ill; int lat, w0;
    rf[7] = 64'd20;
    w0 = wr_cnt;
    csr_op(12'hCF1, 1'b1, 64'd7, rd, ill, lat);
    check("R5 setvl returns new vl", rd, 20);
    check("R8 setvl latency", lat, 3);
    check("R4 reg7 written", rf[7], 20);
    check("R4 one write", wr_cnt - w0, 1);
    csr_op(12'hCF0, 1'b0, '0, rd, ill, lat);
    check("R1 vl read", rd, 20);
    csr_op(12'hCF3, 1'b1, 64'd10, rd, ill, lat);
    check("R2 returns 63", rd, 63);
    rf[9] = 64'd50;
    csr_op(12'hCF1, 1'b1, 64'd9, rd, ill, lat);
    check("R3 vl clamped to mvl", rd, 10);
    check("R4 reg9 clamped value", rf[9], 10);
    rf[5] = 64'd4;
    csr_op(12'hCF1, 1'b1, 64'hFFFF_FF00_0000_0025, rd, ill, lat);
    check("R3 index from low bits", rd, 4);
    check("R4 reg5 written", rf[5], 4);
    check("R3 reg 0x25 idx untouched reg", rf[6], 0);
  endtask

  task automatic t_get_writes();
    logic [XLEN-1:0] rd; logic ill; int lat;
    csr_op(12'hCF0, 1'b1, 64'd55, rd, ill, lat);
    check("R6 CF0 write returns vl", rd, 4);
    csr_op(12'hCF0, 1'b0, '0, rd, ill, lat);
    check("R6 vl unchanged", rd, 4);
    csr_op(12'hCF2, 1'b1, 64'd1, rd, ill, lat);
    check("R6 CF2 write returns mvl", rd, 10);
    csr_op(12'hCF2, 1'b0, '0, rd, ill, lat);
    check("R6 mvl unchanged", rd, 10);
  endtask

  task automatic t_illegal();
    logic [XLEN-1:0] rd; logic ill; int lat, w0;
    w0 = wr_cnt;
    csr_op(12'hCF4, 1'b1, 64'd5, rd, ill, lat);
    check("R9 illegal flag", ill, 1);
    check("R9 rdata zero", rd, 0);
    check("R8 illegal latency", lat, 1);
    csr_op(12'h300, 1'b0, '0, rd, ill, lat);
    check("R9 illegal flag low addr", ill, 1);
    check("R9 no rf write", wr_cnt - w0, 0);
    csr_op(12'hCF0, 1'b0, '0, rd, ill, lat);
    check("R9 vl unchanged", rd, 4);
    check("R9 flag low on legal", ill, 0);
    csr_op(12'hCF2, 1'b0, '0, rd, ill, lat);
    check("R9 mvl unchanged", rd, 10);
  endtask

  task automatic t_index_zero();
    logic [XLEN-1:0] rd; logic ill; int lat, w0;
    w0 = wr_cnt;
    csr_op(12'hCF1, 1'b1, 64'd0, rd, ill, lat);
    check("R4 idx0 vl", rd, 0);
    check("R4 idx0 no write", wr_cnt - w0, 0);
    check("R8 idx0 latency", lat, 3);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setvl_zero_max();
    t_set_mvl();
    t_set_vl();
    t_get_writes();
    t_illegal();
    t_index_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_bad++;
    $display("FAIL R8: watchdog expired, actual %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule